// File: doc/BRIEF.md
# Configuration Ordered-Set Receiver with Clock-Correction Tolerance

This block follows the 8b/10b decoder of a serial transceiver lane. Each clock it takes one decoded byte with its control flag, the lane's clock-correction count and the elastic-buffer status. It finds the two kinds of four-byte configuration ordered set and the two-byte idle ordered set. From a configuration set it extracts the 16-bit configuration word. It reports three things to the auto-negotiation logic: a valid configuration word, an idle-seen pulse and a buffer-error pulse.

The elastic buffer in front of the block can insert or delete a comma/data pair inside a configuration set, which leaves fragments in the stream. The block does not decode such a fragment as a bad configuration word. It uses the side-band clock-correction count to spot the disturbed set, discards it without raising an error, and aligns again on the next comma. An elastic-buffer underflow or overflow produces a single-cycle error pulse and returns the parser to comma search.

Top module: `cfg_oset_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `cfg_valid`, `idle_seen`, `buf_err`, `cfg_is_c2` and `cfg_word` to zero.
- R2: The sequence comma (0xBC with K set), 0xB5, byte A, byte B, with all three data bytes having K clear, gives `cfg_valid` high for the cycle after byte B. In that cycle `cfg_word` = {B, A}, so the first data byte is the low byte, and `cfg_is_c2` = 0.
- R3: The same sequence with 0x42 as the second byte gives `cfg_valid` with `cfg_word` = {B, A} and `cfg_is_c2` = 1.
- R4: Comma followed by data byte 0x50 gives an `idle_seen` pulse of one cycle in the cycle after the 0x50, and `cfg_valid` stays low.
- R5: `cfg_valid` is high for exactly one cycle per set. `cfg_word` and `cfg_is_c2` keep their value until the next valid set, and sets that fail do not change them.
- R6: A byte whose `rx_cc_cnt` is nonzero ends any set in progress without output or error. That byte contributes nothing, even if it is a comma. The next unflagged comma starts a new set that decodes normally.
- R7: A comma that arrives where a configuration data byte is expected aborts the current set and counts as the first byte of a new one.
- R8: A control byte other than the comma in any position after the comma, or a second byte other than 0xB5, 0x42 or 0x50, ends the set with no output.
- R9: When `rx_buf_stat[2]` is 1 (underflow or overflow), the byte is ignored and the parser returns to comma search. `buf_err` is high for one cycle, in the cycle after the first byte of each run of error status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Decoded byte |
| rx_is_k | input | 1 | Byte is a control character |
| rx_cc_cnt | input | 3 | Clock-correction count; nonzero marks an insert/delete event on this byte |
| rx_buf_stat | input | 3 | Elastic-buffer status; bit 2 set means underflow/overflow |
| cfg_word | output | 16 | Last valid configuration word, low byte first on the line |
| cfg_is_c2 | output | 1 | Last valid set was the 0x42 variant |
| cfg_valid | output | 1 | One-cycle pulse: `cfg_word` was just updated |
| idle_seen | output | 1 | One-cycle pulse: idle ordered set received |
| buf_err | output | 1 | One-cycle pulse: elastic-buffer error began |

## Verification
Some properties are checked on every cycle. A control byte, a flagged clock-correction byte or an error-status byte never leads to a valid word on the next cycle. The valid, idle and error pulses never coincide. The word holds between valid pulses, and every error pulse follows error status. The directed scenarios cover the rest: the values of the decoded word, the byte order and set type, recovery from inserted comma/data fragments, aborts by an early comma and the single pulse for a held error. These depend on a multi-byte history that a short property cannot carry.

// File: rtl/cfg_oset_pkg.sv
// Package: shared constants and parser state type for the ordered-set receiver.
// Assumes 8-bit decoded symbols with a separate control flag.
package cfg_oset_pkg;
    localparam logic [7:0] SYM_COMMA = 8'hBC; // comma control character
    localparam logic [7:0] SYM_CFG_A = 8'hB5; // second byte, first config set variant
    localparam logic [7:0] SYM_CFG_B = 8'h42; // second byte, second config set variant
    localparam logic [7:0] SYM_IDLE  = 8'h50; // second byte of the idle set

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,  // waiting for a comma
        ST_COMMA = 2'd1,  // comma seen, expecting set type byte
        ST_LO    = 2'd2,  // expecting low config byte
        ST_HI    = 2'd3   // expecting high config byte
    } pstate_t;
endpackage

// File: rtl/cfg_oset_classify.sv
// Module: cfg_oset_classify
// Purely combinational symbol classifier. It flags the comma, the three
// recognised second bytes, plain data and the clock-correction event.
// Assumes the codes in cfg_oset_pkg and that a nonzero count marks an event.
module cfg_oset_classify
    import cfg_oset_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CC_W   = 3
) (
    input  logic [DATA_W-1:0] sym,
    input  logic              sym_k,
    input  logic [CC_W-1:0]   cc_cnt,
    output logic              is_comma,
    output logic              is_cfg_a,
    output logic              is_cfg_b,
    output logic              is_idle2,
    output logic              is_data,
    output logic              cc_event
);
    localparam logic [CC_W-1:0] CC_NONE = '0;

    // Decode the current symbol against the known codes.
    always_comb begin
        is_comma = sym_k  && (sym == DATA_W'(SYM_COMMA));
        is_cfg_a = !sym_k && (sym == DATA_W'(SYM_CFG_A));
        is_cfg_b = !sym_k && (sym == DATA_W'(SYM_CFG_B));
        is_idle2 = !sym_k && (sym == DATA_W'(SYM_IDLE));
        is_data  = !sym_k;
        cc_event = (cc_cnt != CC_NONE);
    end
endmodule

// File: rtl/cfg_oset_buferr.sv
// Module: cfg_oset_buferr
// Elastic-buffer error detector. It exposes the raw error level for the
// parser and a registered one-cycle pulse on the first cycle of an error run.
// Assumes one status bit (ERR_BIT) carries the underflow/overflow indication.
module cfg_oset_buferr #(
    parameter int BS_W    = 3,
    parameter int ERR_BIT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BS_W-1:0] buf_stat,
    output logic            err_level,
    output logic            err_pulse
);
    logic err_prev;

    // Extract the error indication from the status field.
    always_comb begin
        err_level = buf_stat[ERR_BIT];
    end

    // Remember the last level and emit a pulse on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_prev  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_prev  <= err_level;
            err_pulse <= err_level && !err_prev;
        end
    end
endmodule

// File: rtl/cfg_oset_parser.sv
// Module: cfg_oset_parser
// Ordered-set alignment state machine and word assembly. It takes classified
// symbols and registers the config word, set type and the valid/idle pulses.
// Assumes classification is combinational on the same cycle's byte. Clock-
// correction and buffer-error bytes void any set in progress without error.
module cfg_oset_parser
    import cfg_oset_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sym,
    input  logic              sym_k,
    input  logic              is_comma,
    input  logic              is_cfg_a,
    input  logic              is_cfg_b,
    input  logic              is_idle2,
    input  logic              is_data,
    input  logic              cc_event,
    input  logic              err_level,
    output logic [WORD_W-1:0] word_q,
    output logic              word_is_b_q,
    output logic              word_vld_q,
    output logic              idle_q
);
    pstate_t           st_q, st_d;
    logic [DATA_W-1:0] lo_q;
    logic              pend_b_q;
    logic              void_now;
    logic              take_lo, take_hi, take_type, take_idle;

    // Decide whether this byte is discarded outright.
    always_comb begin
        void_now = err_level || cc_event;
    end

    // Next-state and capture strobes for the alignment machine.
    always_comb begin
        st_d      = st_q;
        take_lo   = 1'b0;
        take_hi   = 1'b0;
        take_type = 1'b0;
        take_idle = 1'b0;
        if (void_now) begin
            st_d = ST_HUNT;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    if (is_comma) st_d = ST_COMMA;
                end
                ST_COMMA: begin
                    if (is_comma) begin
                        st_d = ST_COMMA;
                    end else if (is_cfg_a || is_cfg_b) begin
                        st_d      = ST_LO;
                        take_type = 1'b1;
                    end else if (is_idle2) begin
                        st_d      = ST_HUNT;
                        take_idle = 1'b1;
                    end else begin
                        st_d = ST_HUNT;
                    end
                end
                ST_LO: begin
                    if (is_comma) begin
                        st_d = ST_COMMA;
                    end else if (is_data) begin
                        st_d    = ST_HI;
                        take_lo = 1'b1;
                    end else begin
                        st_d = ST_HUNT;
                    end
                end
                ST_HI: begin
                    if (is_comma) begin
                        st_d = ST_COMMA;
                    end else if (is_data) begin
                        st_d    = ST_HUNT;
                        take_hi = 1'b1;
                    end else begin
                        st_d = ST_HUNT;
                    end
                end
                default: st_d = ST_HUNT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // Hold the set type and low byte while a set is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_b_q <= 1'b0;
            lo_q     <= '0;
        end else begin
            if (take_type) pend_b_q <= is_cfg_b;
            if (take_lo)   lo_q     <= sym;
        end
    end

    // Publish the completed word and the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q      <= '0;
            word_is_b_q <= 1'b0;
            word_vld_q  <= 1'b0;
            idle_q      <= 1'b0;
        end else begin
            word_vld_q <= take_hi;
            idle_q     <= take_idle;
            if (take_hi) begin
                word_q      <= {sym, lo_q};
                word_is_b_q <= pend_b_q;
            end
        end
    end

    // sym_k is consumed through the classifier flags; keep it referenced.
    logic unused_k;
    always_comb unused_k = sym_k;
endmodule

// File: rtl/cfg_oset_rx.sv
// Module: cfg_oset_rx (top)
// Configuration/idle ordered-set receiver that tolerates clock-correction
// fragments. It wires the classifier, buffer-error detector and parser.
// Assumes one decoded byte per clock with side-band correction and status.
module cfg_oset_rx #(
    parameter int DATA_W  = 8,
    parameter int CC_W    = 3,
    parameter int BS_W    = 3,
    parameter int ERR_BIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     rx_byte,
    input  logic                  rx_is_k,
    input  logic [CC_W-1:0]       rx_cc_cnt,
    input  logic [BS_W-1:0]       rx_buf_stat,
    output logic [2*DATA_W-1:0]   cfg_word,
    output logic                  cfg_is_c2,
    output logic                  cfg_valid,
    output logic                  idle_seen,
    output logic                  buf_err
);
    localparam int WORD_W = 2 * DATA_W;

    logic is_comma, is_cfg_a, is_cfg_b, is_idle2, is_data, cc_event;
    logic err_level;

    cfg_oset_classify #(.DATA_W(DATA_W), .CC_W(CC_W)) u_classify (
        .sym      (rx_byte),
        .sym_k    (rx_is_k),
        .cc_cnt   (rx_cc_cnt),
        .is_comma (is_comma),
        .is_cfg_a (is_cfg_a),
        .is_cfg_b (is_cfg_b),
        .is_idle2 (is_idle2),
        .is_data  (is_data),
        .cc_event (cc_event)
    );

    cfg_oset_buferr #(.BS_W(BS_W), .ERR_BIT(ERR_BIT)) u_buferr (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_stat  (rx_buf_stat),
        .err_level (err_level),
        .err_pulse (buf_err)
    );

    cfg_oset_parser #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym         (rx_byte),
        .sym_k       (rx_is_k),
        .is_comma    (is_comma),
        .is_cfg_a    (is_cfg_a),
        .is_cfg_b    (is_cfg_b),
        .is_idle2    (is_idle2),
        .is_data     (is_data),
        .cc_event    (cc_event),
        .err_level   (err_level),
        .word_q      (cfg_word),
        .word_is_b_q (cfg_is_c2),
        .word_vld_q  (cfg_valid),
        .idle_q      (idle_seen)
    );
endmodule

// File: rtl/cfg_oset_rx_sva.sv
// Module: cfg_oset_rx_sva
// Port-level protocol checker for cfg_oset_rx, attached with bind below.
module cfg_oset_rx_sva #(
    parameter int DATA_W  = 8,
    parameter int CC_W    = 3,
    parameter int BS_W    = 3,
    parameter int ERR_BIT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_is_k,
    input logic [CC_W-1:0]     rx_cc_cnt,
    input logic [BS_W-1:0]     rx_buf_stat,
    input logic [2*DATA_W-1:0] cfg_word,
    input logic                cfg_is_c2,
    input logic                cfg_valid,
    input logic                idle_seen,
    input logic                buf_err
);
    // R5: a valid word is a single-cycle pulse.
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);

    // R5: word and type hold between valid pulses.
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> ($stable(cfg_word) && $stable(cfg_is_c2)));

    // R6: a clock-correction byte never completes a set.
    p_cc_void_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cc_cnt != '0) |=> (!cfg_valid && !idle_seen));

    // R8: a control byte can never be the closing byte of a set.
    p_k_no_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_is_k |=> !cfg_valid);

    // R9: an error-status byte produces no set output.
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_stat[ERR_BIT] |=> (!cfg_valid && !idle_seen));

    // R9: every error pulse is preceded by error status.
    p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_err |-> $past(rx_buf_stat[ERR_BIT]));

    // R4: valid, idle and error pulses never coincide.
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_valid, idle_seen, buf_err}));
endmodule

bind cfg_oset_rx cfg_oset_rx_sva #(
    .DATA_W(DATA_W), .CC_W(CC_W), .BS_W(BS_W), .ERR_BIT(ERR_BIT)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_is_k     (rx_is_k),
    .rx_cc_cnt   (rx_cc_cnt),
    .rx_buf_stat (rx_buf_stat),
    .cfg_word    (cfg_word),
    .cfg_is_c2   (cfg_is_c2),
    .cfg_valid   (cfg_valid),
    .idle_seen   (idle_seen),
    .buf_err     (buf_err)
);

// File: tb/cfg_oset_rx_bench.sv
// Directed bench for cfg_oset_rx: one task per scenario, each self-checking.
module cfg_oset_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_is_k = 1'b0;
    logic [2:0]  rx_cc_cnt = 3'd0;
    logic [2:0]  rx_buf_stat = 3'd0;
    logic [15:0] cfg_word;
    logic        cfg_is_c2, cfg_valid, idle_seen, buf_err;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    cfg_oset_rx u_cfg_oset_rx (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_is_k(rx_is_k),
        .rx_cc_cnt(rx_cc_cnt), .rx_buf_stat(rx_buf_stat),
        .cfg_word(cfg_word), .cfg_is_c2(cfg_is_c2), .cfg_valid(cfg_valid),
        .idle_seen(idle_seen), .buf_err(buf_err)
    );

    // Present one byte at a falling edge; return at the next falling edge so
    // outputs registered from that byte are visible.
    task automatic put(input logic [7:0] b, input logic k,
                       input logic [2:0] cc, input logic [2:0] bs);
        rx_byte = b; rx_is_k = k; rx_cc_cnt = cc; rx_buf_stat = bs;
        @(negedge clk);
    endtask

    task automatic d(input logic [7:0] b); put(b, 1'b0, 3'd0, 3'd0); endtask
    task automatic comma(); put(8'hBC, 1'b1, 3'd0, 3'd0); endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1", "cfg_valid", 16'(cfg_valid), 16'd0);
        chk("R1", "idle_seen", 16'(idle_seen), 16'd0);
        chk("R1", "buf_err",   16'(buf_err),   16'd0);
        chk("R1", "cfg_word",  cfg_word,       16'h0000);
        chk("R1", "cfg_is_c2", 16'(cfg_is_c2), 16'd0);
    endtask

    task automatic t_c1();
        comma(); d(8'hB5); d(8'h34);
        chk("R2", "no early valid", 16'(cfg_valid), 16'd0);
        d(8'h12);
        chk("R2", "cfg_valid", 16'(cfg_valid), 16'd1);
        chk("R2", "cfg_word",  cfg_word,       16'h1234);
        chk("R2", "cfg_is_c2", 16'(cfg_is_c2), 16'd0);
        d(8'h00);
        chk("R5", "valid drops", 16'(cfg_valid), 16'd0);
        chk("R5", "word held",   cfg_word,       16'h1234);
    endtask

    task automatic t_c2();
        comma(); d(8'h42); d(8'hCD); d(8'hAB);
        chk("R3", "cfg_valid", 16'(cfg_valid), 16'd1);
        chk("R3", "cfg_word",  cfg_word,       16'hABCD);
        chk("R3", "cfg_is_c2", 16'(cfg_is_c2), 16'd1);
        d(8'h00);
    endtask

    task automatic t_idle();
        comma(); d(8'h50);
        chk("R4", "idle_seen", 16'(idle_seen), 16'd1);
        chk("R4", "no valid",  16'(cfg_valid), 16'd0);
        d(8'h00);
        chk("R4", "idle pulse ends", 16'(idle_seen), 16'd0);
        chk("R5", "word unchanged by idle", cfg_word, 16'hABCD);
    endtask

    task automatic t_ccfrag();
        // Inserted comma/data pair flagged on the comma, then stray bytes.
        comma(); d(8'hB5); put(8'hBC, 1'b1, 3'd1, 3'd0); d(8'hB5);
        d(8'h11); d(8'h22);
        chk("R6", "fragment no valid", 16'(cfg_valid), 16'd0);
        chk("R6", "fragment no error", 16'(buf_err),   16'd0);
        chk("R6", "word unchanged",    cfg_word,       16'hABCD);
        comma(); d(8'hB5); d(8'h33); d(8'h44);
        chk("R6", "realigned valid", 16'(cfg_valid), 16'd1);
        chk("R6", "realigned word",  cfg_word,       16'h4433);
        // Flag on the closing byte voids the set.
        comma(); d(8'hB5); d(8'h77); put(8'h88, 1'b0, 3'd2, 3'd0);
        chk("R6", "flagged last byte", 16'(cfg_valid), 16'd0);
        chk("R6", "word kept",         cfg_word,       16'h4433);
        d(8'h00);
    endtask

    task automatic t_abort();
        comma(); d(8'hB5); comma();
        chk("R7", "abort no valid", 16'(cfg_valid), 16'd0);
        d(8'hB5); d(8'h9A);
        comma(); d(8'h42); d(8'h78); d(8'h56);
        chk("R7", "restart valid", 16'(cfg_valid), 16'd1);
        chk("R7", "restart word",  cfg_word,       16'h5678);
        chk("R7", "restart type",  16'(cfg_is_c2), 16'd1);
        d(8'h00);
    endtask

    task automatic t_otherk();
        comma(); put(8'hFC, 1'b1, 3'd0, 3'd0); d(8'h11); d(8'h22);
        chk("R8", "other K 2nd", 16'(cfg_valid), 16'd0);
        comma(); d(8'h99); d(8'h11); d(8'h22);
        chk("R8", "unknown 2nd", 16'(cfg_valid), 16'd0);
        comma(); d(8'hB5); put(8'hF7, 1'b1, 3'd0, 3'd0); d(8'h22);
        chk("R8", "K as data", 16'(cfg_valid), 16'd0);
        chk("R8", "word kept", cfg_word,       16'h5678);
        d(8'h00);
    endtask

    task automatic t_buferr();
        comma(); d(8'hB5); d(8'h55);
        put(8'h66, 1'b0, 3'd0, 3'd5);
        chk("R9", "pulse", 16'(buf_err),   16'd1);
        chk("R9", "no valid", 16'(cfg_valid), 16'd0);
        put(8'h66, 1'b0, 3'd0, 3'd6);
        chk("R9", "single pulse", 16'(buf_err), 16'd0);
        d(8'h77);
        chk("R9", "set discarded", 16'(cfg_valid), 16'd0);
        comma(); d(8'hB5); d(8'h01); d(8'h02);
        chk("R9", "recovers", cfg_word, 16'h0201);
        d(8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        d(8'h00);
        t_c1();
        t_c2();
        t_idle();
        t_ccfrag();
        t_abort();
        t_otherk();
        t_buferr();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule